// File: doc/BRIEF.md
# IOM-2 Terminal-Mode Frame Splitter

This block sits on the receive side of a terminal-mode IOM-2 link. It takes the 96-bit downstream frame and splits it into its named channel fields. At the same time it shifts the matching upstream fields out onto the upstream line. A frame has three 32-bit subframes and repeats at 8 kHz.

The block runs entirely on the double-rate link clock. Each data bit spans two cycles of that clock, and a rising edge of the frame sync marks bit 0.

The receive fields are parallel registers that all change on the same edge, together with a one-cycle done strobe. The upstream fields are parallel inputs. The block takes a snapshot of them at the start of every frame.

After the first sync edge, the block keeps framing on its own even if the sync goes missing. A sync edge that arrives at an unexpected bit position restarts the frame and sets a sticky error flag.

Top module: `iom2_te_deframer`

## Requirements
- R1: After reset every receive field is 0, `frame_done` and `frame_err` are 0, and `tx_sd` is 1.
- R2: Until the first rising edge of `fsync` has been seen, `tx_sd` stays 1, `frame_done` never rises and the receive fields keep their reset values.
- R3: The clock edge that first samples `fsync` high after it was low is edge 0, which opens bit 0. Bit k of the frame is sampled from `rx_sd` at edge 2k+1 after edge 0. The value of `rx_sd` in the first clock cycle of a bit has no effect.
- R4: Frame bits are numbered so that frame bit 0 is word bit 95. Word bits 95:64 form subframe 0, laid out as: `rx_b1`[95:88], `rx_b2`[87:80], `rx_mon0`[79:72], `rx_dch`[71:70], `rx_ci0`[69:66], `rx_mon0_rf`[65], `rx_mon0_xf`[64]. Each field is sent MSB first.
- R5: Subframe 1 occupies word bits 63:32, laid out as: `rx_icc_a`[63:56], `rx_icc_b`[55:48], `rx_mon1`[47:40], `rx_ci1`[39:34], `rx_mon1_rf`[33], `rx_mon1_xf`[32].
- R6: Subframe 2 occupies word bits 31:0, laid out as: `rx_sf2_raw`[31:8], `rx_ci2`[7:2], `rx_sf2_spare`[1:0].
- R7: All receive fields update on edge 191 after edge 0, which samples bit 95. `frame_done` is high for exactly the cycle after that edge. The fields hold their values at all other times.
- R8: The upstream fields are packed with the same bit positions as R4 to R6. They are captured on the edge that opens bit 0. `tx_sd` then carries word bit 95−k from edge 2k after edge 0 for two clock cycles.
- R9: Once framing is established, if no `fsync` rising edge arrives, the frame wraps after bit 95. The next frame's reception, upstream snapshot and `frame_done` follow exactly as if a sync edge had come on time.
- R10: A `fsync` rising edge that arrives on the edge right after bit 95 completes raises no error. A rising edge at any other bit position restarts the frame at bit 0 on that edge and sets `frame_err`, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Link clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; a rising edge marks bit 0 |
| rx_sd | input | 1 | Downstream serial data |
| tx_b1 | input | 8 | Upstream first user byte |
| tx_b2 | input | 8 | Upstream second user byte |
| tx_mon0 | input | 8 | Upstream monitor byte, subframe 0 |
| tx_dch | input | 2 | Upstream signalling bits |
| tx_ci0 | input | 4 | Upstream command/indication, subframe 0 |
| tx_mon0_rf | input | 1 | Upstream monitor-0 receive handshake |
| tx_mon0_xf | input | 1 | Upstream monitor-0 transmit handshake |
| tx_icc_a | input | 8 | Upstream first intercommunication byte |
| tx_icc_b | input | 8 | Upstream second intercommunication byte |
| tx_mon1 | input | 8 | Upstream monitor byte, subframe 1 |
| tx_ci1 | input | 6 | Upstream command/indication, subframe 1 |
| tx_mon1_rf | input | 1 | Upstream monitor-1 receive handshake |
| tx_mon1_xf | input | 1 | Upstream monitor-1 transmit handshake |
| tx_sf2_raw | input | 24 | Upstream first three bytes of subframe 2 |
| tx_ci2 | input | 6 | Upstream command/indication, subframe 2 |
| tx_sf2_spare | input | 2 | Upstream last two bits of subframe 2 |
| tx_sd | output | 1 | Upstream serial data |
| frame_done | output | 1 | One-cycle strobe when new fields are available |
| frame_err | output | 1 | Sticky misplaced-sync flag |
| rx_b1 | output | 8 | First user byte |
| rx_b2 | output | 8 | Second user byte |
| rx_mon0 | output | 8 | Monitor byte, subframe 0 |
| rx_dch | output | 2 | Signalling bits |
| rx_ci0 | output | 4 | Command/indication, subframe 0 |
| rx_mon0_rf | output | 1 | Monitor-0 receive handshake |
| rx_mon0_xf | output | 1 | Monitor-0 transmit handshake |
| rx_icc_a | output | 8 | First intercommunication byte |
| rx_icc_b | output | 8 | Second intercommunication byte |
| rx_mon1 | output | 8 | Monitor byte, subframe 1 |
| rx_ci1 | output | 6 | Command/indication, subframe 1 |
| rx_mon1_rf | output | 1 | Monitor-1 receive handshake |
| rx_mon1_xf | output | 1 | Monitor-1 transmit handshake |
| rx_sf2_raw | output | 24 | First three bytes of subframe 2 |
| rx_ci2 | output | 6 | Command/indication, subframe 2 |
| rx_sf2_spare | output | 2 | Last two bits of subframe 2 |

## Verification
Counting from the edge that opens bit 0, each result has a fixed due cycle:
- Upstream bit k appears on `tx_sd` at edge 2k and holds for two cycles.
- Downstream bit k is sampled at edge 2k+1.
- The fields and `frame_done` change at edge 191, and `frame_done` falls one edge later.

The bench drives every input on the falling clock edge, so edge 0 is the rising edge right after `fsync` is raised. It reads `tx_sd` half a cycle after each even edge. It reads the fields and `frame_done` half a cycle after edge 191, which is where the next frame starts.

The strobe's one-cycle width is checked inside the following frame. Frames are driven back to back, so every on-time sync edge falls exactly on the expected boundary.

// File: rtl/iom2_te_deframer.sv
module iom2_te_deframer (
  input  logic        clk2x,
  input  logic        rst_n,
  input  logic        fsync,
  input  logic        rx_sd,
  input  logic [7:0]  tx_b1,
  input  logic [7:0]  tx_b2,
  input  logic [7:0]  tx_mon0,
  input  logic [1:0]  tx_dch,
  input  logic [3:0]  tx_ci0,
  input  logic        tx_mon0_rf,
  input  logic        tx_mon0_xf,
  input  logic [7:0]  tx_icc_a,
  input  logic [7:0]  tx_icc_b,
  input  logic [7:0]  tx_mon1,
  input  logic [5:0]  tx_ci1,
  input  logic        tx_mon1_rf,
  input  logic        tx_mon1_xf,
  input  logic [23:0] tx_sf2_raw,
  input  logic [5:0]  tx_ci2,
  input  logic [1:0]  tx_sf2_spare,
  output logic        tx_sd,
  output logic        frame_done,
  output logic        frame_err,
  output logic [7:0]  rx_b1,
  output logic [7:0]  rx_b2,
  output logic [7:0]  rx_mon0,
  output logic [1:0]  rx_dch,
  output logic [3:0]  rx_ci0,
  output logic        rx_mon0_rf,
  output logic        rx_mon0_xf,
  output logic [7:0]  rx_icc_a,
  output logic [7:0]  rx_icc_b,
  output logic [7:0]  rx_mon1,
  output logic [5:0]  rx_ci1,
  output logic        rx_mon1_rf,
  output logic        rx_mon1_xf,
  output logic [23:0] rx_sf2_raw,
  output logic [5:0]  rx_ci2,
  output logic [1:0]  rx_sf2_spare
);

  localparam int FRAME_BITS = 96;
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic                  fsync_q;
  logic                  lock_q;
  logic                  half_q;
  logic [CW-1:0]         bit_q;
  logic [FRAME_BITS-1:0] rx_sh;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_word;
  logic [FRAME_BITS-1:0] tx_word;

  wire sync_rise   = fsync & ~fsync_q;
  wire on_boundary = (bit_q == '0) && !half_q;
  wire cap_en      = lock_q && !sync_rise && half_q && (bit_q == LAST);

  assign rx_word = {rx_sh[FRAME_BITS-2:0], rx_sd};
  assign tx_word = {tx_b1, tx_b2, tx_mon0, tx_dch, tx_ci0, tx_mon0_rf, tx_mon0_xf,
                    tx_icc_a, tx_icc_b, tx_mon1, tx_ci1, tx_mon1_rf, tx_mon1_xf,
                    tx_sf2_raw, tx_ci2, tx_sf2_spare};

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      fsync_q    <= 1'b0;
      lock_q     <= 1'b0;
      half_q     <= 1'b0;
      bit_q      <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      tx_sd      <= 1'b1;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      fsync_q    <= fsync;
      frame_done <= cap_en;
      if (sync_rise) begin
        if (lock_q && !on_boundary)
          frame_err <= 1'b1;
        lock_q <= 1'b1;
        half_q <= 1'b1;
        bit_q  <= '0;
        tx_sd  <= tx_word[FRAME_BITS-1];
        tx_sh  <= {tx_word[FRAME_BITS-2:0], 1'b0};
      end else if (lock_q) begin
        if (half_q) begin
          half_q <= 1'b0;
          rx_sh  <= rx_word;
          bit_q  <= (bit_q == LAST) ? '0 : bit_q + CW'(1);
        end else begin
          half_q <= 1'b1;
          if (bit_q == '0) begin
            tx_sd <= tx_word[FRAME_BITS-1];
            tx_sh <= {tx_word[FRAME_BITS-2:0], 1'b0};
          end else begin
            tx_sd <= tx_sh[FRAME_BITS-1];
            tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      rx_b1 <= '0; rx_b2 <= '0; rx_mon0 <= '0; rx_dch <= '0; rx_ci0 <= '0;
      rx_mon0_rf <= 1'b0; rx_mon0_xf <= 1'b0;
      rx_icc_a <= '0; rx_icc_b <= '0; rx_mon1 <= '0; rx_ci1 <= '0;
      rx_mon1_rf <= 1'b0; rx_mon1_xf <= 1'b0;
      rx_sf2_raw <= '0; rx_ci2 <= '0; rx_sf2_spare <= '0;
    end else if (cap_en) begin
      rx_b1        <= rx_word[95:88];
      rx_b2        <= rx_word[87:80];
      rx_mon0      <= rx_word[79:72];
      rx_dch       <= rx_word[71:70];
      rx_ci0       <= rx_word[69:66];
      rx_mon0_rf   <= rx_word[65];
      rx_mon0_xf   <= rx_word[64];
      rx_icc_a     <= rx_word[63:56];
      rx_icc_b     <= rx_word[55:48];
      rx_mon1      <= rx_word[47:40];
      rx_ci1       <= rx_word[39:34];
      rx_mon1_rf   <= rx_word[33];
      rx_mon1_xf   <= rx_word[32];
      rx_sf2_raw   <= rx_word[31:8];
      rx_ci2       <= rx_word[7:2];
      rx_sf2_spare <= rx_word[1:0];
    end
  end

endmodule

// File: rtl/iom2_te_deframer_chk.sv
module iom2_te_deframer_chk (
  input logic        clk2x,
  input logic        rst_n,
  input logic        frame_done,
  input logic        frame_err,
  input logic        tx_sd,
  input logic        locked,
  input logic [95:0] fields
);

  p_done_pulse_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_fields_hold_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
    !frame_done |-> $stable(fields));

  p_idle_high_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
    !locked |-> tx_sd);

  p_done_locked_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
    frame_done |-> locked);

  p_err_sticky_r10: assert property (@(posedge clk2x) disable iff (!rst_n)
    frame_err |=> frame_err);

endmodule

bind iom2_te_deframer iom2_te_deframer_chk u_chk (
  .clk2x      (clk2x),
  .rst_n      (rst_n),
  .frame_done (frame_done),
  .frame_err  (frame_err),
  .tx_sd      (tx_sd),
  .locked     (lock_q),
  .fields     ({rx_b1, rx_b2, rx_mon0, rx_dch, rx_ci0, rx_mon0_rf, rx_mon0_xf,
                rx_icc_a, rx_icc_b, rx_mon1, rx_ci1, rx_mon1_rf, rx_mon1_xf,
                rx_sf2_raw, rx_ci2, rx_sf2_spare})
);

// File: tb/test_iom2_te_deframer.sv
module test_iom2_te_deframer;
  localparam int CLK_PERIOD = 10;

  logic clk2x = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic rx_sd = 1'b0;
  logic [7:0] tx_b1, tx_b2, tx_mon0, tx_icc_a, tx_icc_b, tx_mon1;
  logic [1:0] tx_dch, tx_sf2_spare;
  logic [3:0] tx_ci0;
  logic [5:0] tx_ci1, tx_ci2;
  logic tx_mon0_rf, tx_mon0_xf, tx_mon1_rf, tx_mon1_xf;
  logic [23:0] tx_sf2_raw;
  logic tx_sd, frame_done, frame_err;
  logic [7:0] rx_b1, rx_b2, rx_mon0, rx_icc_a, rx_icc_b, rx_mon1;
  logic [1:0] rx_dch, rx_sf2_spare;
  logic [3:0] rx_ci0;
  logic [5:0] rx_ci1, rx_ci2;
  logic rx_mon0_rf, rx_mon0_xf, rx_mon1_rf, rx_mon1_xf;
  logic [23:0] rx_sf2_raw;

  int checks = 0;
  int errors = 0;
  logic [95:0] du_cap;
  int mid_done;

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  iom2_te_deframer i_iom2_te_deframer (
    .clk2x(clk2x), .rst_n(rst_n), .fsync(fsync), .rx_sd(rx_sd),
    .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon0(tx_mon0), .tx_dch(tx_dch), .tx_ci0(tx_ci0),
    .tx_mon0_rf(tx_mon0_rf), .tx_mon0_xf(tx_mon0_xf),
    .tx_icc_a(tx_icc_a), .tx_icc_b(tx_icc_b), .tx_mon1(tx_mon1), .tx_ci1(tx_ci1),
    .tx_mon1_rf(tx_mon1_rf), .tx_mon1_xf(tx_mon1_xf),
    .tx_sf2_raw(tx_sf2_raw), .tx_ci2(tx_ci2), .tx_sf2_spare(tx_sf2_spare),
    .tx_sd(tx_sd), .frame_done(frame_done), .frame_err(frame_err),
    .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon0(rx_mon0), .rx_dch(rx_dch), .rx_ci0(rx_ci0),
    .rx_mon0_rf(rx_mon0_rf), .rx_mon0_xf(rx_mon0_xf),
    .rx_icc_a(rx_icc_a), .rx_icc_b(rx_icc_b), .rx_mon1(rx_mon1), .rx_ci1(rx_ci1),
    .rx_mon1_rf(rx_mon1_rf), .rx_mon1_xf(rx_mon1_xf),
    .rx_sf2_raw(rx_sf2_raw), .rx_ci2(rx_ci2), .rx_sf2_spare(rx_sf2_spare)
  );

  wire [31:0] sf0 = {rx_b1, rx_b2, rx_mon0, rx_dch, rx_ci0, rx_mon0_rf, rx_mon0_xf};
  wire [31:0] sf1 = {rx_icc_a, rx_icc_b, rx_mon1, rx_ci1, rx_mon1_rf, rx_mon1_xf};
  wire [31:0] sf2 = {rx_sf2_raw, rx_ci2, rx_sf2_spare};

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_tx(input logic [95:0] w);
    {tx_b1, tx_b2, tx_mon0, tx_dch, tx_ci0, tx_mon0_rf, tx_mon0_xf,
     tx_icc_a, tx_icc_b, tx_mon1, tx_ci1, tx_mon1_rf, tx_mon1_xf,
     tx_sf2_raw, tx_ci2, tx_sf2_spare} = w;
  endtask

  task automatic send_frame(input logic [95:0] w, input int nbits, input bit sync, input bit glitch);
    mid_done = 0;
    for (int k = 0; k < nbits; k++) begin
      fsync = sync && (k == 0);
      rx_sd = glitch ? ~w[95-k] : w[95-k];
      @(negedge clk2x);
      du_cap[95-k] = tx_sd;
      if (frame_done) mid_done++;
      rx_sd = w[95-k];
      @(negedge clk2x);
    end
  endtask

  task automatic check_fields(input string tag, input logic [95:0] w);
    chk({tag, " sf0 R4"}, 96'(sf0), 96'(w[95:64]));
    chk({tag, " sf1 R5"}, 96'(sf1), 96'(w[63:32]));
    chk({tag, " sf2 R6"}, 96'(sf2), 96'(w[31:0]));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; fsync = 1'b0; rx_sd = 1'b0;
    repeat (3) @(negedge clk2x);
    rst_n = 1'b1;
    @(negedge clk2x);
    chk("reset fields R1", {sf0, sf1, sf2}, 96'h0);
    chk("reset frame_done R1", 96'(frame_done), 96'h0);
    chk("reset frame_err R1", 96'(frame_err), 96'h0);
    chk("reset tx_sd R1", 96'(tx_sd), 96'h1);
  endtask

  task automatic t_unlocked;
    set_tx(96'h0);
    du_cap = '1;
    send_frame(96'h5A_C3_0F_F0_96_69_A5_3C_E1_1E_7B_B7, 96, 0, 0);
    chk("unlocked tx_sd high R2", du_cap, {96{1'b1}});
    chk("unlocked no strobe R2", 96'(mid_done + int'(frame_done)), 96'h0);
    chk("unlocked fields R2", {sf0, sf1, sf2}, 96'h0);
  endtask

  task automatic t_first_frame;
    logic [95:0] rw = 96'h3C_A5_E1_9B_5A_0F_C3_6D_81_7E_24_D9;
    logic [95:0] tw = 96'hD2_4B_70_8E_19_F6_3A_C5_66_0D_B1_97;
    set_tx(tw);
    send_frame(rw, 96, 1, 0);
    check_fields("first", rw);
    chk("first strobe R7", 96'(frame_done), 96'h1);
    chk("first no early strobe R7", 96'(mid_done), 96'h0);
    chk("first upstream R8", du_cap, tw);
    chk("first no error R10", 96'(frame_err), 96'h0);
  endtask

  task automatic t_second_half_sample;
    logic [95:0] rw = 96'hF0_0F_AA_55_C3_3C_99_66_01_80_7F_FE;
    logic [95:0] tw = 96'h12_34_56_78_9A_BC_DE_F0_0F_ED_CB_A9;
    set_tx(tw);
    send_frame(rw, 96, 1, 1);
    chk("second-half sampling R3", {sf0, sf1, sf2}, rw);
    chk("strobe one cycle R7", 96'(mid_done), 96'h0);
    chk("on-time sync no error R10", 96'(frame_err), 96'h0);
    chk("back-to-back upstream R8", du_cap, tw);
  endtask

  task automatic t_flywheel;
    logic [95:0] rw = 96'h6E_D1_2C_B3_44_8F_E7_19_5B_A0_C6_3D;
    logic [95:0] tw = 96'hAB_CD_EF_01_23_45_67_89_FE_DC_BA_98;
    set_tx(tw);
    send_frame(rw, 96, 0, 0);
    chk("flywheel fields R9", {sf0, sf1, sf2}, rw);
    chk("flywheel strobe R9", 96'(frame_done), 96'h1);
    chk("flywheel upstream R9", du_cap, tw);
    chk("flywheel no error R10", 96'(frame_err), 96'h0);
  endtask

  task automatic t_resync;
    logic [95:0] rw = 96'h0D_E2_71_98_C4_3B_5F_A6_20_19_8E_F7;
    logic [95:0] tw = 96'h77_00_FF_11_EE_22_DD_33_CC_44_BB_55;
    send_frame(96'h11_22_33_44_55_66_77_88_99_AA_BB_CC, 40, 1, 0);
    chk("partial frame no error R10", 96'(frame_err), 96'h0);
    set_tx(tw);
    send_frame(rw, 96, 1, 0);
    chk("misplaced sync flag R10", 96'(frame_err), 96'h1);
    chk("resync fields R10", {sf0, sf1, sf2}, rw);
    chk("resync upstream R10", du_cap, tw);
    send_frame(96'h3C_A5_E1_9B_5A_0F_C3_6D_81_7E_24_D9, 96, 1, 0);
    chk("error sticky R10", 96'(frame_err), 96'h1);
    check_fields("after resync", 96'h3C_A5_E1_9B_5A_0F_C3_6D_81_7E_24_D9);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_tx(96'h0);
    @(negedge clk2x);
    t_reset();
    t_unlocked();
    t_first_frame();
    t_second_half_sample();
    t_flywheel();
    t_resync();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule